// File: doc/BRIEF.md
# Significance-Tracking Floating-Point Multiplier

This block multiplies two floating-point operands whose mantissas carry an explicit leading bit. Leading zeros in an operand's mantissa are treated as a statement of how many bits of that operand are meaningful. The block does not return a fully normalized product. It places the result so that its count of leading zeros matches the less precise operand, or is one lower. Downstream arithmetic can then see how much precision survived the multiplication. The mantissa-comparison rule in the requirements picks between the two counts. Near the top of the exponent range, the block gives up this tracking and returns a normalized value so that it does not overflow.

Operands enter on a valid/ready input channel and results leave on a valid/ready output channel. Each operation takes a fixed time, and the block holds one operation at a time. While an operation is in flight, `in_ready` stays low, and the upstream side must keep its operand on the port until the block accepts it. A finished result waits on the output, unchanged, until the consumer raises `out_ready`. Back-pressure on the output therefore stalls the input. The sign is the exclusive-or of the operand signs. Bits that fall below the mantissa are truncated.

Top module: `sigmul_top`

## Requirements
- R1: An operand or result is packed as {sign, exponent[EW-1:0], mantissa[MW-1:0]} with the sign in the top bit. Its value is mantissa/2^MW × 2^(exponent−BIAS). The mantissa has no hidden bit, and its leading-zero count L is the number of zero bits above its highest set bit.
- R2: The result sign is the exclusive-or of the two operand signs, for every outcome including zero, flush and overflow.
- R3: An operand pair is accepted on a rising edge where in_valid and in_ready are both high. in_ready is high only when no operation is held. out_valid rises on the second rising edge after the accepting edge and is low in between.
- R4: While out_valid is high and out_ready is low, out_res and out_ovf stay unchanged and in_ready stays low. in_valid presented while the block is busy is neither accepted nor queued.
- R5: Let P be the exact mantissa product, N the top MW bits of P shifted left until its top bit is set, and Lmax the larger operand leading-zero count. When the counts differ, the result keeps Lmax leading zeros if N>>Lmax ≥ the mantissa of the operand with more leading zeros. Otherwise it gets Lmax−1 leading zeros.
- R6: When both counts are equal, the result keeps that count only if N>>Lmax is ≥ both operand mantissas. Otherwise it gets one fewer, but never fewer than zero.
- R7: The result mantissa is N shifted right by the chosen count. N is truncated from P, and the bits shifted out are dropped with no rounding.
- R8: The result exponent is ea+eb−BIAS−(left shift applied to P)+(chosen count). If that exceeds 2^EW−1 but the normalized exponent does not, the result is N with the normalized exponent and out_ovf low.
- R9: If the normalized exponent exceeds 2^EW−1, out_ovf is high and the exponent and mantissa fields are all ones.
- R10: If either mantissa is zero, the result mantissa is zero, the exponent is the larger operand exponent, and out_ovf is low.
- R11: If the result exponent would be negative, the result has exponent 0 and mantissa 0, with out_ovf low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block idle and able to accept |
| in_a | input | 1+EW+MW | First operand |
| in_b | input | 1+EW+MW | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 1+EW+MW | Product in the operand format |
| out_ovf | output | 1 | Exponent overflow, result saturated |

## Verification
The bench builds the block with MW=8, EW=5 and BIAS=15. With a 5-bit exponent, a single multiplication can reach the top of the range. That puts both the normalized fallback and true overflow within reach, along with the exact boundary between them, and flush to zero below the range. With 8-bit mantissas, every product and leading-zero decision can be worked out by hand for the directed cases. These include the one-fewer case, the equal-count case clamped at zero, and truncation of set bits. A pseudo-random sweep with varied leading-zero counts is compared against an arithmetic model in the bench.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHAPE = 2'd1,
    ST_DONE  = 2'd2
  } sm_state_e;
endpackage

// File: rtl/sigmul_lzc.sv
module sigmul_lzc #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  // Ascending scan: the highest set bit is the last to write the count.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/sigmul_shape.sv
module sigmul_shape #(
  parameter int MW   = 16,
  parameter int EW   = 8,
  parameter int BIAS = 127
) (
  input  logic [2*MW-1:0]          prod,
  input  logic [MW-1:0]            ma,
  input  logic [MW-1:0]            mb,
  input  logic [$clog2(MW+1)-1:0]  lza,
  input  logic [$clog2(MW+1)-1:0]  lzb,
  input  logic [EW-1:0]            ea,
  input  logic [EW-1:0]            eb,
  output logic [EW-1:0]            r_exp,
  output logic [MW-1:0]            r_mant,
  output logic                     r_ovf
);
  localparam int PW  = 2 * MW;
  localparam int LZW = $clog2(MW + 1);
  localparam int PCW = $clog2(PW + 1);
  localparam int XW  = EW + $clog2(PW) + 3;
  localparam logic signed [XW-1:0] EMAX = XW'((1 << EW) - 1);

  logic [PCW-1:0]         lzp;
  logic [PW-1:0]          pnorm;
  logic [MW-1:0]          nrm;
  logic [MW-1:0]          cand;
  logic [LZW-1:0]         lmax;
  logic [LZW-1:0]         tgt;
  logic                   keep;
  logic                   zero_op;
  logic signed [XW-1:0]   e_norm;
  logic signed [XW-1:0]   e_unn;

  sigmul_lzc #(.W(PW), .CW(PCW)) u_plzc (.din(prod), .cnt(lzp));

  always_comb begin
    zero_op = (ma == '0) || (mb == '0);
    pnorm   = prod << lzp;
    nrm     = pnorm[PW-1:MW];
    lmax    = (lza > lzb) ? lza : lzb;
    cand    = nrm >> lmax;
    if (lza > lzb)      keep = (cand >= ma);
    else if (lzb > lza) keep = (cand >= mb);
    else                keep = (cand >= ma) && (cand >= mb);
    if (keep)              tgt = lmax;
    else if (lmax == '0)   tgt = '0;
    else                   tgt = lmax - LZW'(1);
    e_norm = $signed(XW'(ea) + XW'(eb) - XW'(BIAS) - XW'(lzp));
    e_unn  = e_norm + $signed(XW'(tgt));
  end

  // Priority: zero operand, true overflow, fallback, underflow, tracked result.
  always_comb begin
    r_ovf = 1'b0;
    if (zero_op) begin
      r_exp  = (ea > eb) ? ea : eb;
      r_mant = '0;
    end else if (e_norm > EMAX) begin
      r_ovf  = 1'b1;
      r_exp  = '1;
      r_mant = '1;
    end else if (e_unn > EMAX) begin
      r_exp  = e_norm[EW-1:0];
      r_mant = nrm;
    end else if (e_unn < 0) begin
      r_exp  = '0;
      r_mant = '0;
    end else begin
      r_exp  = e_unn[EW-1:0];
      r_mant = nrm >> tgt;
    end
  end
endmodule

// File: rtl/sigmul_top.sv
module sigmul_top #(
  parameter int MW   = 16,
  parameter int EW   = 8,
  parameter int BIAS = 127,
  parameter int OW   = 1 + EW + MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [OW-1:0] in_a,
  input  logic [OW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_res,
  output logic          out_ovf
);
  import sigmul_pkg::*;
  localparam int LZW = $clog2(MW + 1);
  localparam int PW  = 2 * MW;

  sm_state_e st;
  logic [MW-1:0]  opm [2];
  logic [LZW-1:0] opl [2];
  logic           acc;

  assign opm[0] = in_a[MW-1:0];
  assign opm[1] = in_b[MW-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_oplzc
    sigmul_lzc #(.W(MW), .CW(LZW)) u_lzc (.din(opm[g]), .cnt(opl[g]));
  end

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_DONE);
  assign acc       = in_valid && in_ready;

  logic           sgn_q;
  logic [EW-1:0]  ea_q, eb_q;
  logic [MW-1:0]  ma_q, mb_q;
  logic [LZW-1:0] lza_q, lzb_q;
  logic [PW-1:0]  prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q  <= 1'b0;
      ea_q   <= '0;
      eb_q   <= '0;
      ma_q   <= '0;
      mb_q   <= '0;
      lza_q  <= '0;
      lzb_q  <= '0;
      prod_q <= '0;
    end else if (acc) begin
      sgn_q  <= in_a[OW-1] ^ in_b[OW-1];
      ea_q   <= in_a[MW+EW-1:MW];
      eb_q   <= in_b[MW+EW-1:MW];
      ma_q   <= opm[0];
      mb_q   <= opm[1];
      lza_q  <= opl[0];
      lzb_q  <= opl[1];
      prod_q <= PW'(opm[0]) * PW'(opm[1]);
    end
  end

  logic [EW-1:0] r_exp;
  logic [MW-1:0] r_mant;
  logic          r_ovf;

  sigmul_shape #(.MW(MW), .EW(EW), .BIAS(BIAS)) u_shape (
    .prod(prod_q), .ma(ma_q), .mb(mb_q), .lza(lza_q), .lzb(lzb_q),
    .ea(ea_q), .eb(eb_q), .r_exp(r_exp), .r_mant(r_mant), .r_ovf(r_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      out_res <= '0;
      out_ovf <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE:  if (in_valid) st <= ST_SHAPE;
        ST_SHAPE: begin
          out_res <= {sgn_q, r_exp, r_mant};
          out_ovf <= r_ovf;
          st      <= ST_DONE;
        end
        ST_DONE:  if (out_ready) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sigmul_chk.sv
module sigmul_chk #(
  parameter int MW = 16,
  parameter int EW = 8,
  parameter int OW = 1 + EW + MW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [OW-1:0] in_a,
  input logic [OW-1:0] in_b,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_res,
  input logic          out_ovf
);
  logic          c_sgn, c_zero;
  logic [EW-1:0] c_emax;
  logic [EW-1:0] ea, eb;
  logic          take;

  assign ea   = in_a[MW+EW-1:MW];
  assign eb   = in_b[MW+EW-1:MW];
  assign take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_sgn  <= 1'b0;
      c_zero <= 1'b0;
      c_emax <= '0;
    end else if (take) begin
      c_sgn  <= in_a[OW-1] ^ in_b[OW-1];
      c_zero <= (in_a[MW-1:0] == '0) || (in_b[MW-1:0] == '0);
      c_emax <= (ea > eb) ? ea : eb;
    end
  end

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_res[OW-1] == c_sgn); // R2
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !out_valid ##1 out_valid); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_res) && $stable(out_ovf)); // R4
  AST_NO_ACCEPT_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R4
  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> out_res[OW-2:0] == '1); // R9
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_zero) |-> (out_res[MW-1:0] == '0) && !out_ovf
                              && (out_res[MW+EW-1:MW] == c_emax)); // R10
endmodule

bind sigmul_top sigmul_chk #(.MW(MW), .EW(EW), .OW(OW)) u_chk (.*);

// File: tb/tb_sigmul_top.sv
module tb_sigmul_top;
  localparam int MW   = 8;
  localparam int EW   = 5;
  localparam int BIAS = 15;
  localparam int OW   = 1 + EW + MW;
  localparam int EMAX = (1 << EW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [OW-1:0] in_a = '0;
  logic [OW-1:0] in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OW-1:0] out_res;
  logic          out_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sigmul_top #(.MW(MW), .EW(EW), .BIAS(BIAS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_ovf(out_ovf)
  );

  function automatic logic [OW-1:0] mk(input bit s, input int e, input int m);
    return {s, EW'(e), MW'(m)};
  endfunction

  // Arithmetic model built from the requirements; returns {ovf, result}.
  function automatic logic [OW:0] model(input logic [OW-1:0] a, input logic [OW-1:0] b);
    int ma, mb, ea, eb, la, lb, lmax, p, lp, n, cand, t, en, eu;
    bit s, keep;
    ma = int'(a[MW-1:0]);      mb = int'(b[MW-1:0]);
    ea = int'(a[MW+EW-1:MW]);  eb = int'(b[MW+EW-1:MW]);
    s  = a[OW-1] ^ b[OW-1];
    if (ma == 0 || mb == 0) return {1'b0, s, EW'(ea > eb ? ea : eb), MW'(0)};
    la = 0; while (((ma >> (MW-1-la)) & 1) == 0) la++;
    lb = 0; while (((mb >> (MW-1-lb)) & 1) == 0) lb++;
    p  = ma * mb;
    lp = 0; while (((p >> (2*MW-1-lp)) & 1) == 0) lp++;
    n  = (p << lp) >> MW;
    lmax = (la > lb) ? la : lb;
    cand = n >> lmax;
    if (la > lb)      keep = (cand >= ma);
    else if (lb > la) keep = (cand >= mb);
    else              keep = (cand >= ma) && (cand >= mb);
    t  = keep ? lmax : ((lmax > 0) ? lmax - 1 : 0);
    en = ea + eb - BIAS - lp;
    eu = en + t;
    if (en > EMAX) return {1'b1, s, {EW{1'b1}}, {MW{1'b1}}};
    if (eu > EMAX) return {1'b0, s, EW'(en), MW'(n)};
    if (eu < 0)    return {1'b0, s, EW'(0), MW'(0)};
    return {1'b0, s, EW'(eu), MW'(n >> t)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One operation, checking acceptance, latency and the result.
  task automatic run_op(input logic [OW-1:0] a, input logic [OW-1:0] b,
                        input logic [OW-1:0] er, input logic eo, input string req);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    chk({req, " R3 in_ready idle"}, 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R3 no early valid"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    chk({req, " R3 valid at latency"}, 32'(out_valid), 32'd1);
    chk({req, " result"}, 32'(out_res), 32'(er));
    chk({req, " ovf"}, 32'(out_ovf), 32'(eo));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R3 reset in_ready", 32'(in_ready), 32'd1);
    chk("R3 reset out_valid", 32'(out_valid), 32'd0);
    chk("R9 reset out_ovf", 32'(out_ovf), 32'd0);
  endtask

  task automatic t_tracking();
    run_op(mk(0,15,8'h80), mk(0,15,8'h80), mk(0,14,8'h80), 0, "R1 R6 normalized pair");
    run_op(mk(0,15,8'h10), mk(0,16,8'h80), mk(0,15,8'h10), 0, "R5 keep Lmax");
    run_op(mk(0,15,8'h18), mk(0,15,8'hA0), mk(0,14,8'h1E), 0, "R5 keep Lmax b<1");
    run_op(mk(0,15,8'h18), mk(0,15,8'hF0), mk(0,14,8'h2D), 0, "R5 one fewer");
    run_op(mk(0,15,8'h3F), mk(0,15,8'h21), mk(0,12,8'h40), 0, "R6 equal counts one fewer");
    run_op(mk(0,15,8'hC0), mk(0,15,8'hC0), mk(0,15,8'h90), 0, "R6 clamp at zero");
    run_op(mk(0,15,8'h18), mk(0,15,8'hFF), mk(0,14,8'h2F), 0, "R7 truncation");
  endtask

  task automatic t_sign();
    run_op(mk(1,15,8'h80), mk(0,15,8'h80), mk(1,14,8'h80), 0, "R2 one negative");
    run_op(mk(1,15,8'h80), mk(1,15,8'h80), mk(0,14,8'h80), 0, "R2 both negative");
  endtask

  task automatic t_range();
    run_op(mk(0,31,8'h10), mk(0,16,8'h80), mk(0,31,8'h10), 0, "R8 top exponent fits");
    run_op(mk(0,31,8'h10), mk(0,17,8'h80), mk(0,29,8'h80), 0, "R8 fallback normalized");
    run_op(mk(1,31,8'h80), mk(0,31,8'h80), mk(1,31,8'hFF), 1, "R9 overflow saturates");
    run_op(mk(0,0,8'h80),  mk(1,0,8'h80),  mk(1,0,8'h00),  0, "R11 flush below range");
  endtask

  task automatic t_zero();
    run_op(mk(1,7,8'h00),  mk(0,20,8'h80), mk(1,20,8'h00), 0, "R10 zero a");
    run_op(mk(0,31,8'h80), mk(0,30,8'h00), mk(0,31,8'h00), 0, "R10 zero b no ovf");
  endtask

  // Input held valid through a busy period, and output held back.
  task automatic t_busy_backpressure();
    logic [OW-1:0] first;
    first = mk(0,15,8'h18);
    @(negedge clk);
    in_a = first; in_b = mk(0,15,8'hF0); in_valid = 1'b1;
    @(negedge clk);
    in_a = mk(0,20,8'h80); in_b = mk(0,20,8'h80);
    chk("R4 busy in_ready low", 32'(in_ready), 32'd0);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk("R4 held valid", 32'(out_valid), 32'd1);
      chk("R4 held result", 32'(out_res), 32'(mk(0,14,8'h2D)));
      chk("R4 in_ready low while full", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R4 nothing queued", 32'(out_valid), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'h1234_5678;
    logic [OW-1:0] a, b;
    logic [OW:0] m;
    for (int k = 0; k < 48; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      a = {lf[0], EW'(8 + lf[5:1] % 16), MW'(lf[15:8] >> lf[18:16])};
      b = {lf[1], EW'(8 + lf[23:19] % 16), MW'(lf[31:24] >> lf[7:6])};
      m = model(a, b);
      run_op(a, b, m[OW-1:0], m[OW], "R5 R6 R7 sweep");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tracking();
    t_sign();
    t_range();
    t_zero();
    t_busy_backpressure();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule